// File: doc/BRIEF.md
# Multi-Source Soft Reset Sequencer

This block runs the device-level reset sequence. Four kinds of request reach it: a power-on reset input, an active-low external reset pin, a reset bit written by software, and a watchdog expiry. It answers with an active-low reset status, a reset for controller state machines, a separate reset for configuration registers, a clock-pause enable, a boot-mode capture strobe and a one-cycle boot-start pulse.

A power-on reset clears everything, including the configuration registers. It also captures the boot-mode strap pins again. A soft reset (pin, software bit or watchdog) resets only the state machines. Configuration registers and the captured boot mode keep their values. After the initialization window, the system clocks are held off for eight cycles, and only then is boot started.

All request inputs pass through two-flop synchronizers. A power-on pulse that is too short is filtered out. A soft request that arrives while a sequence is running is dropped. Control and status pins are plain levels or pulses. No stream interface is involved, so there is no back-pressure.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While a filtered power-on reset is active, `rst_stat_n`, `sm_rst_n` and `cfg_rst_n` are low, and `clk_pause` and `boot_start` are low.
- R2: A synchronized low on `por_n` that lasts fewer than POR_MIN (default 16) cycles does not start any sequence. A low of at least POR_MIN + 4 cycles always does.
- R3: On power-on release, `boot_latch` pulses for one cycle, then `boot_mode` holds the value of `boot_pins`. Next come INIT_CYC (default 64) cycles with all three resets low. Then `boot_start` pulses for one cycle, with no clock pause.
- R4: Any of these starts a soft sequence: a falling edge on `rst_pin_n`, a rising edge on `sw_rst_req`, or a rising edge on `wdog_expire`. `rst_stat_n` goes low on the third clock edge after the input changes.
- R5: During a soft sequence, `rst_stat_n` and `sm_rst_n` stay low for exactly INIT_CYC cycles while `cfg_rst_n` stays high.
- R6: After a soft sequence, `clk_pause` is high for exactly 8 cycles. It starts at the edge where `rst_stat_n` returns high, and all resets are released during the pause.
- R7: `boot_start` is high for one cycle, at the cycle right after the clock pause ends.
- R8: A soft reset leaves `boot_mode` unchanged, even if `boot_pins` have changed.
- R9: Soft requests that arrive while a sequence is in progress are ignored. A reset pin held low past the end of the sequence does not retrigger it.
- R10: A power-on reset that arrives during a soft sequence aborts it. All three resets go low, and the power-on sequence of R3 follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Power-on reset request, active low, asynchronous |
| rst_pin_n | input | 1 | External soft reset pin, active low, asynchronous |
| sw_rst_req | input | 1 | Software reset request bit, active high |
| wdog_expire | input | 1 | Watchdog expiry, active high |
| boot_pins | input | BOOT_W | Boot-mode strap pins |
| rst_stat_n | output | 1 | Reset status, low while an internal reset is in progress |
| sm_rst_n | output | 1 | Reset for controller state machines, active low |
| cfg_rst_n | output | 1 | Reset for configuration registers, active low, power-on only |
| clk_pause | output | 1 | High while system clocks are to be gated off |
| boot_latch | output | 1 | One-cycle strobe when boot pins are captured |
| boot_mode | output | BOOT_W | Captured boot-mode value |
| boot_start | output | 1 | One-cycle pulse that starts the boot sequence |

## Verification
The sequence is exercised with each of the three soft sources in turn, including a pin held low past the end of the sequence. This separates edge-triggered starts from level-triggered ones. Randomized runs change the strap pins and inject extra requests during the initialization and pause windows, which separates the retained boot mode and the busy-time ignoring from a design that re-samples the pins or restarts. Power-on pulses just below and well above the minimum test the filter. A power-on reset injected during a soft sequence shows that power-on takes precedence and that the straps are captured again.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_POR_HOLD = 3'd1,
    ST_INIT     = 3'd2,
    ST_PAUSE    = 3'd3,
    ST_BOOT     = 3'd4
  } seq_state_e;

  localparam int PAUSE_LEN = 8;
  localparam int NUM_SOFT_SRC = 3;
endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    logic [STAGES-1:0] shreg;
    always_ff @(posedge clk) begin
      shreg <= {shreg[STAGES-2:0], din[g]};
    end
    assign dout[g] = shreg[STAGES-1];
  end
endmodule

// File: rtl/rsq_por_filter.sv
module rsq_por_filter #(
  parameter int POR_MIN = 16
) (
  input  logic clk,
  input  logic por_s_n,
  output logic por_act
);
  localparam int CW = $clog2(POR_MIN + 1);
  logic [CW-1:0] low_cnt;

  always_ff @(posedge clk) begin
    if (por_s_n)
      low_cnt <= '0;
    else if (low_cnt != CW'(POR_MIN))
      low_cnt <= low_cnt + 1'b1;
  end

  assign por_act = (low_cnt == CW'(POR_MIN));

  // R2: filtered reset only follows a synchronized low level
  p_act_follows_low_r2: assert property (@(posedge clk)
    por_act |-> $past(!por_s_n));
endmodule

// File: rtl/rsq_req_edge.sv
module rsq_req_edge
  import rsq_pkg::*;
(
  input  logic clk,
  input  logic pin_s_n,
  input  logic sw_s,
  input  logic wd_s,
  output logic soft_go
);
  logic [NUM_SOFT_SRC-1:0] act, act_q, rise;

  assign act = {~pin_s_n, sw_s, wd_s};

  always_ff @(posedge clk) begin
    act_q <= act;
  end

  for (genvar g = 0; g < NUM_SOFT_SRC; g++) begin : g_src
    assign rise[g] = act[g] & ~act_q[g];
  end

  assign soft_go = |rise;
endmodule

// File: rtl/rsq_fsm.sv
module rsq_fsm
  import rsq_pkg::*;
#(
  parameter int BOOT_W   = 8,
  parameter int INIT_CYC = 64
) (
  input  logic              clk,
  input  logic              por_act,
  input  logic              soft_go,
  input  logic [BOOT_W-1:0] boot_pins,
  output logic              rst_stat_n,
  output logic              sm_rst_n,
  output logic              cfg_rst_n,
  output logic              clk_pause,
  output logic              boot_latch,
  output logic [BOOT_W-1:0] boot_mode,
  output logic              boot_start
);
  localparam int ICW = (INIT_CYC > 1) ? $clog2(INIT_CYC) : 1;
  localparam int PCW = $clog2(PAUSE_LEN);
  localparam int RCW = $clog2(PAUSE_LEN + 1);

  seq_state_e        state;
  logic [ICW-1:0]    icnt;
  logic [PCW-1:0]    pcnt;
  logic              por_kind;

  always_ff @(posedge clk) begin
    if (por_act) begin
      state    <= ST_POR_HOLD;
      por_kind <= 1'b1;
      icnt     <= '0;
      pcnt     <= '0;
    end else begin
      case (state)
        ST_IDLE: if (soft_go) begin
          state    <= ST_INIT;
          por_kind <= 1'b0;
          icnt     <= '0;
        end
        ST_POR_HOLD: begin
          state     <= ST_INIT;
          boot_mode <= boot_pins;
          icnt      <= '0;
        end
        ST_INIT: begin
          if (icnt == ICW'(INIT_CYC - 1)) begin
            icnt  <= '0;
            pcnt  <= '0;
            state <= por_kind ? ST_BOOT : ST_PAUSE;
          end else begin
            icnt <= icnt + 1'b1;
          end
        end
        ST_PAUSE: begin
          pcnt <= pcnt + 1'b1;
          if (pcnt == PCW'(PAUSE_LEN - 1)) state <= ST_BOOT;
        end
        ST_BOOT: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  logic in_reset;
  assign in_reset   = (state == ST_POR_HOLD) || (state == ST_INIT);
  assign rst_stat_n = ~in_reset;
  assign sm_rst_n   = ~in_reset;
  assign cfg_rst_n  = ~((state == ST_POR_HOLD) || ((state == ST_INIT) && por_kind));
  assign clk_pause  = (state == ST_PAUSE);
  assign boot_latch = (state == ST_POR_HOLD) && !por_act;
  assign boot_start = (state == ST_BOOT);

  // checker-side run length of the clock pause
  logic [RCW-1:0] pause_run;
  always_ff @(posedge clk) begin
    if (clk_pause) pause_run <= pause_run + 1'b1;
    else           pause_run <= '0;
  end

  // R1: the cycle after a power-on reset was active, all resets are low
  p_por_holds_resets_r1: assert property (@(posedge clk) disable iff (por_act)
    $past(por_act) |-> (!rst_stat_n && !sm_rst_n && !cfg_rst_n));

  // R5: a soft sequence keeps configuration registers out of reset
  p_cfg_kept_r5: assert property (@(posedge clk) disable iff (por_act)
    (!rst_stat_n && !por_kind) |-> cfg_rst_n);

  // R6: clocks are paused only with every reset released
  p_pause_released_r6: assert property (@(posedge clk) disable iff (por_act)
    clk_pause |-> (rst_stat_n && sm_rst_n && cfg_rst_n));

  // R6: pause window is exactly PAUSE_LEN cycles
  p_pause_len_r6: assert property (@(posedge clk) disable iff (por_act)
    ($fell(clk_pause) && !$past(por_act)) |-> (pause_run == RCW'(PAUSE_LEN)));

  // R7: a soft-reset boot start comes right after the pause
  p_boot_after_pause_r7: assert property (@(posedge clk) disable iff (por_act)
    (boot_start && !por_kind) |-> $past(clk_pause));

  // R8: boot mode only moves on a capture strobe
  p_mode_hold_r8: assert property (@(posedge clk) disable iff (por_act)
    !$past(boot_latch) |-> $stable(boot_mode));
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl #(
  parameter int BOOT_W      = 8,
  parameter int INIT_CYC    = 64,
  parameter int POR_MIN     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              rst_pin_n,
  input  logic              sw_rst_req,
  input  logic              wdog_expire,
  input  logic [BOOT_W-1:0] boot_pins,
  output logic              rst_stat_n,
  output logic              sm_rst_n,
  output logic              cfg_rst_n,
  output logic              clk_pause,
  output logic              boot_latch,
  output logic [BOOT_W-1:0] boot_mode,
  output logic              boot_start
);
  logic [3:0] raw_in, sync_out;
  logic       por_act, soft_go;

  assign raw_in = {por_n, rst_pin_n, sw_rst_req, wdog_expire};

  rsq_sync #(.W(4), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .din  (raw_in),
    .dout (sync_out)
  );

  rsq_por_filter #(.POR_MIN(POR_MIN)) u_por (
    .clk     (clk),
    .por_s_n (sync_out[3]),
    .por_act (por_act)
  );

  rsq_req_edge u_edge (
    .clk     (clk),
    .pin_s_n (sync_out[2]),
    .sw_s    (sync_out[1]),
    .wd_s    (sync_out[0]),
    .soft_go (soft_go)
  );

  rsq_fsm #(.BOOT_W(BOOT_W), .INIT_CYC(INIT_CYC)) u_fsm (
    .clk        (clk),
    .por_act    (por_act),
    .soft_go    (soft_go),
    .boot_pins  (boot_pins),
    .rst_stat_n (rst_stat_n),
    .sm_rst_n   (sm_rst_n),
    .cfg_rst_n  (cfg_rst_n),
    .clk_pause  (clk_pause),
    .boot_latch (boot_latch),
    .boot_mode  (boot_mode),
    .boot_start (boot_start)
  );
endmodule

// File: tb/sim_rst_seq_ctrl.sv
module sim_rst_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int BOOT_W   = 8;
  localparam int INIT_CYC = 64;
  localparam int POR_MIN  = 16;

  logic clk = 1'b0;
  logic por_n, rst_pin_n, sw_rst_req, wdog_expire;
  logic [BOOT_W-1:0] boot_pins;
  logic rst_stat_n, sm_rst_n, cfg_rst_n, clk_pause, boot_latch, boot_start;
  logic [BOOT_W-1:0] boot_mode;

  int n_tests = 0;
  int n_fail  = 0;
  logic [BOOT_W-1:0] exp_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  rst_seq_ctrl #(.BOOT_W(BOOT_W), .INIT_CYC(INIT_CYC), .POR_MIN(POR_MIN)) u0 (
    .clk(clk), .por_n(por_n), .rst_pin_n(rst_pin_n), .sw_rst_req(sw_rst_req),
    .wdog_expire(wdog_expire), .boot_pins(boot_pins), .rst_stat_n(rst_stat_n),
    .sm_rst_n(sm_rst_n), .cfg_rst_n(cfg_rst_n), .clk_pause(clk_pause),
    .boot_latch(boot_latch), .boot_mode(boot_mode), .boot_start(boot_start)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [2:0] soft_view(input logic st, input logic sm, input logic cf);
    return {st, sm, cf};
  endfunction

  // power-on release, starting at a negedge with por_n already held low
  task automatic por_release();
    int bad = 0;
    por_n = 1'b1;
    step(); step(); step();
    chk("R3 boot_latch strobe", boot_latch, 1);
    exp_mode = boot_pins;
    step();
    chk("R3 boot_latch one cycle", boot_latch, 0);
    chk("R3 boot_mode captured", boot_mode, exp_mode);
    chk("R3 resets low in init", soft_view(rst_stat_n, sm_rst_n, cfg_rst_n), 3'b000);
    for (int i = 1; i < INIT_CYC; i++) begin
      step();
      if (soft_view(rst_stat_n, sm_rst_n, cfg_rst_n) != 3'b000 || clk_pause) bad++;
    end
    chk("R3 init window length", bad, 0);
    step();
    chk("R3 boot_start after init", boot_start, 1);
    chk("R3 no clock pause on power-on", clk_pause, 0);
    chk("R3 status released", rst_stat_n, 1);
    step();
    chk("R3 boot_start single cycle", boot_start, 0);
  endtask

  task automatic soft_seq(input int src, input bit inject);
    int bad = 0;
    case (src)
      0: rst_pin_n = 1'b0;
      1: sw_rst_req = 1'b1;
      default: wdog_expire = 1'b1;
    endcase
    step(); step();
    chk("R4 not yet in reset", rst_stat_n, 1);
    step();
    chk("R4 R5 reset entered, cfg kept", soft_view(rst_stat_n, sm_rst_n, cfg_rst_n), 3'b001);
    sw_rst_req = 1'b0;
    wdog_expire = 1'b0;
    for (int i = 1; i < INIT_CYC; i++) begin
      step();
      if (soft_view(rst_stat_n, sm_rst_n, cfg_rst_n) != 3'b001) bad++;
      if (inject) begin
        if (i == 5) wdog_expire = 1'b1;
        if (i == 7) wdog_expire = 1'b0;
        if (i == 9) sw_rst_req = 1'b1;
        if (i == 11) sw_rst_req = 1'b0;
      end
    end
    chk("R5 init window soft", bad, 0);
    step();
    chk("R6 pause starts with status release", {rst_stat_n, clk_pause}, 2'b11);
    bad = 0;
    for (int p = 1; p < 8; p++) begin
      step();
      if (!clk_pause || !sm_rst_n || !cfg_rst_n) bad++;
      if (inject && p == 2) sw_rst_req = 1'b1;
      if (inject && p == 3) sw_rst_req = 1'b0;
    end
    chk("R6 pause length", bad, 0);
    step();
    chk("R7 boot_start after pause", {boot_start, clk_pause}, 2'b10);
    step();
    chk("R7 boot_start single cycle", boot_start, 0);
    chk("R8 boot_mode retained", boot_mode, exp_mode);
    bad = 0;
    for (int k = 0; k < 12; k++) begin
      step();
      if (!rst_stat_n || clk_pause || boot_start) bad++;
    end
    chk("R9 no retrigger after sequence", bad, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int bad;
    void'($urandom(32'd4242));
    por_n = 1'b0; rst_pin_n = 1'b1; sw_rst_req = 1'b0; wdog_expire = 1'b0;
    boot_pins = 8'hA5;
    @(negedge clk);
    repeat (POR_MIN + 8) step();
    chk("R1 resets low under power-on", soft_view(rst_stat_n, sm_rst_n, cfg_rst_n), 3'b000);
    chk("R1 pause and boot quiet", {clk_pause, boot_start}, 2'b00);
    por_release();
    repeat (5) step();

    // R2: short power-on pulse filtered
    por_n = 1'b0;
    repeat (POR_MIN - 6) step();
    por_n = 1'b1;
    bad = 0;
    for (int k = 0; k < 24; k++) begin
      step();
      if (!rst_stat_n || !cfg_rst_n) bad++;
    end
    chk("R2 short power-on ignored", bad, 0);
    chk("R2 boot_mode untouched", boot_mode, exp_mode);

    // directed soft resets, pins changed to prove retention
    boot_pins = 8'h3C;
    soft_seq(0, 1'b0);
    rst_pin_n = 1'b1;
    repeat (4) step();
    soft_seq(1, 1'b1);
    soft_seq(2, 1'b1);

    // randomized soft resets
    for (int r = 0; r < 6; r++) begin
      int src;
      src = int'($urandom % 3);
      boot_pins = BOOT_W'($urandom);
      soft_seq(src, bit'($urandom % 2));
      rst_pin_n = 1'b1;
      repeat (int'($urandom % 5) + 2) step();
    end

    // R10: power-on aborts a soft sequence
    boot_pins = 8'h5A;
    sw_rst_req = 1'b1;
    repeat (3) step();
    sw_rst_req = 1'b0;
    repeat (20) step();
    chk("R10 soft sequence running", soft_view(rst_stat_n, sm_rst_n, cfg_rst_n), 3'b001);
    por_n = 1'b0;
    repeat (POR_MIN + 6) step();
    chk("R10 power-on overrides soft", soft_view(rst_stat_n, sm_rst_n, cfg_rst_n), 3'b000);
    chk("R10 no pause under power-on", clk_pause, 0);
    por_release();
    chk("R10 straps recaptured", boot_mode, 8'h5A);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule